// File: doc/BRIEF.md
# Serial Flash Read-Fetch Sequencer

This block fetches words from a serial NOR flash so that a processor can run code straight out of it. A fetch request carries a byte address. The sequencer builds a complete read frame on the serial pins. The frame is an optional 8-bit read opcode, then the address, then an optional stretch of mode clocks, then 32 data bits shifted in from the device. The block then hands the word back with a one-cycle valid strobe.

Each of the opcode, address and data phases has its own lane width: one, two or four data lines. The address can be 24 or 32 bits. The opcode can be omitted for devices that stay in a continuous-read state. The serial clock period, the chip-select polarity and the chip-select setup and release spacing are set by static configuration inputs. These inputs are held steady while a frame is running.

Top module: `xip_fetch_seq`

## Requirements
- R1: `req_ready` is high only while no frame is active. A request is taken on a clock where both `req_valid` and `req_ready` are high, and `req_ready` is low on the next cycle. After reset `req_ready` is high, `rdata_valid` is low, the serial clock is low and no data line is driven.
- R2: A frame ends with `rdata_valid` high for exactly one cycle. `rdata` then holds the 32 bits that were shifted in, first bit received in bit 31. In that same cycle chip select is already inactive.
- R3: Lane code per phase: 0 = one line, 1 = two lines, 2 or 3 = four lines. One-line output uses line 0 and one-line input uses line 1. Two-line mode uses lines 1:0 and four-line mode uses lines 3:0. The frame's clock count is the sum over its phases of each phase's bit count divided by that phase's lane count. Bits go most significant first, and the highest-numbered line carries the most significant bit of each group.
- R4: With `cfg_skip_cmd` set, the frame starts with the address phase and no opcode clocks are sent.
- R5: With `cfg_addr32` clear, the address phase sends `req_addr[23:0]`. With it set, the phase sends all 32 bits.
- R6: After the address, the block sends `cfg_mode_clks` clocks, and a value of 0 means none. On every one of them `cfg_mode_val` is on lines 3:0 with all four output enables high.
- R7: Inside a frame, the serial clock is high for `cfg_sck_hi` system clocks and low for `cfg_sck_lo` system clocks, with a value of 0 acting as 1. The serial clock is low whenever chip select is inactive.
- R8: Chip select is active high when `cfg_cs_active_high` is set and active low otherwise.
- R9: The first rising serial clock edge comes exactly `cfg_cs_lead` + 1 + low-time system clocks after chip select becomes active. When the next request is already waiting, chip select stays inactive for exactly `cfg_cs_trail` + 2 system clocks between frames.
- R10: Output data changes only on falling serial clock edges and input data is taken on rising ones. During the data phase, and while no frame is active, all four output enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_opcode | input | 8 | Read opcode |
| cfg_cmd_lanes | input | 2 | Opcode phase lane code |
| cfg_addr_lanes | input | 2 | Address and mode phase lane code |
| cfg_data_lanes | input | 2 | Data phase lane code |
| cfg_addr32 | input | 1 | 1 = 32-bit address, 0 = 24-bit |
| cfg_skip_cmd | input | 1 | 1 = omit the opcode phase |
| cfg_mode_clks | input | MODE_W | Number of mode clocks |
| cfg_mode_val | input | 4 | Value driven during mode clocks |
| cfg_sck_hi | input | CNT_W | Serial clock high time in system clocks |
| cfg_sck_lo | input | CNT_W | Serial clock low time in system clocks |
| cfg_cs_active_high | input | 1 | Chip-select polarity |
| cfg_cs_lead | input | CNT_W | Extra setup clocks before the first edge |
| cfg_cs_trail | input | CNT_W | Extra release clocks after a frame |
| req_valid | input | 1 | Fetch request |
| req_addr | input | 32 | Fetch byte address |
| req_ready | output | 1 | Sequencer can take a request |
| rdata | output | WORD_W | Fetched word |
| rdata_valid | output | 1 | One-cycle strobe for `rdata` |
| spi_sck | output | 1 | Serial clock |
| spi_cs | output | 1 | Chip select |
| spi_io_out | output | 4 | Data line output values |
| spi_io_oe | output | 4 | Data line output enables |
| spi_io_in | input | 4 | Data line input values |

## Verification
The bound checker watches several rules on every cycle. It checks that the valid strobe lasts one cycle and arrives with chip select released, that the request handshake drops ready, and that the serial clock rests low outside a frame. It also checks each high pulse against the programmed width, that the output enables only take the four legal lane shapes, and that they are all low when idle. A flash model in the bench covers what needs a whole frame to show. It captures the opcode and address lane by lane and counts the clocks of each phase. It also checks the mode value, the chip-select setup and release spacing and the assembled data word, across lane mixes, both address sizes, both polarities and the no-opcode mode.

// File: rtl/xip_fetch_pkg.sv
// Shared types and helpers for the serial flash fetch sequencer.
// Assumes lane codes 0/1/2 mean one/two/four lines; code 3 acts as four.
package xip_fetch_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TRAIL
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_CMD,
        PH_ADDR,
        PH_MODE,
        PH_DATA
    } phase_t;

    // log2 of the number of lines selected by a lane code
    function automatic logic [1:0] lane_log2(input logic [1:0] code);
        case (code)
            2'd0:    lane_log2 = 2'd0;
            2'd1:    lane_log2 = 2'd1;
            default: lane_log2 = 2'd2;
        endcase
    endfunction

    // number of bits moved per serial clock for a lane code
    function automatic logic [2:0] lane_bits(input logic [1:0] code);
        lane_bits = 3'(3'd1 << lane_log2(code));
    endfunction

endpackage

// File: rtl/xip_sck_gen.sv
// Serial clock generator. While run is high it produces a clock that
// stays low for lo_cnt and high for hi_cnt system clocks (0 acts as 1).
// rise/fall flag the system clock edge at which sck changes level.
// Assumes run drops only after a fall, so sck is low whenever run is low.
module xip_sck_gen #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] hi_cnt,
    input  logic [CNT_W-1:0] lo_cnt,
    output logic             sck,
    output logic             rise,
    output logic             fall
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] hi_lim;
    logic [CNT_W-1:0] lo_lim;

    // clamp a zero width to one system clock
    always_comb begin
        hi_lim = (hi_cnt == '0) ? CNT_W'(1) : hi_cnt;
        lo_lim = (lo_cnt == '0) ? CNT_W'(1) : lo_cnt;
    end

    // edge flags for the current system clock
    always_comb begin
        rise = run && !sck && (cnt == lo_lim - CNT_W'(1));
        fall = run &&  sck && (cnt == hi_lim - CNT_W'(1));
    end

    // level and width counter of the serial clock
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            sck <= 1'b0;
            cnt <= '0;
        end else if (rise) begin
            sck <= 1'b1;
            cnt <= '0;
        end else if (fall) begin
            sck <= 1'b0;
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/xip_lane_tx.sv
// Output lane mux. Places the top bits of the transmit shift register on
// the data lines for the opcode and address phases, the mode value on all
// four lines during mode clocks, and releases every line otherwise.
// Purely combinational; tx_top is bits [31:28] of the shift register.
module xip_lane_tx
    import xip_fetch_pkg::*;
(
    input  logic       drive_en,
    input  phase_t     phase,
    input  logic [1:0] cmd_lanes,
    input  logic [1:0] addr_lanes,
    input  logic [3:0] tx_top,
    input  logic [3:0] mode_val,
    output logic [3:0] io_out,
    output logic [3:0] io_oe
);
    logic [1:0] lanes;

    // choose the lane code of the phase being sent
    always_comb lanes = (phase == PH_CMD) ? cmd_lanes : addr_lanes;

    // map shift register bits to lines, highest line takes the MSB
    always_comb begin
        io_out = 4'h0;
        io_oe  = 4'h0;
        if (drive_en && phase != PH_DATA) begin
            if (phase == PH_MODE) begin
                io_out = mode_val;
                io_oe  = 4'hF;
            end else begin
                case (lanes)
                    2'd0: begin
                        io_out = {3'b000, tx_top[3]};
                        io_oe  = 4'h1;
                    end
                    2'd1: begin
                        io_out = {2'b00, tx_top[3:2]};
                        io_oe  = 4'h3;
                    end
                    default: begin
                        io_out = tx_top;
                        io_oe  = 4'hF;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/xip_lane_rx.sv
// Input assembler. On each enabled strobe shifts in one, two or four bits
// from the data lines (line 1 alone in one-line mode), MSB first.
// Assumes WORD_W is a multiple of four so every lane width fills the word.
module xip_lane_rx #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic [1:0]        lanes,
    input  logic [3:0]        io_in,
    output logic [WORD_W-1:0] word
);
    // collect the sampled line group into the low end of the word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
        end else if (shift_en) begin
            case (lanes)
                2'd0:    word <= {word[WORD_W-2:0], io_in[1]};
                2'd1:    word <= {word[WORD_W-3:0], io_in[1:0]};
                default: word <= {word[WORD_W-5:0], io_in};
            endcase
        end
    end

endmodule

// File: rtl/xip_fetch_seq.sv
// Serial flash read-fetch sequencer. Takes one fetch request at a time and
// runs opcode, address, mode and data phases on the serial pins, each with
// its own lane width, then returns the fetched word with a one-cycle strobe.
// Assumes all cfg_* inputs are steady while a frame is in progress.
module xip_fetch_seq
    import xip_fetch_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int CNT_W  = 4,
    parameter int MODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        cfg_opcode,
    input  logic [1:0]        cfg_cmd_lanes,
    input  logic [1:0]        cfg_addr_lanes,
    input  logic [1:0]        cfg_data_lanes,
    input  logic              cfg_addr32,
    input  logic              cfg_skip_cmd,
    input  logic [MODE_W-1:0] cfg_mode_clks,
    input  logic [3:0]        cfg_mode_val,
    input  logic [CNT_W-1:0]  cfg_sck_hi,
    input  logic [CNT_W-1:0]  cfg_sck_lo,
    input  logic              cfg_cs_active_high,
    input  logic [CNT_W-1:0]  cfg_cs_lead,
    input  logic [CNT_W-1:0]  cfg_cs_trail,
    input  logic              req_valid,
    input  logic [31:0]       req_addr,
    output logic              req_ready,
    output logic [WORD_W-1:0] rdata,
    output logic              rdata_valid,
    output logic              spi_sck,
    output logic              spi_cs,
    output logic [3:0]        spi_io_out,
    output logic [3:0]        spi_io_oe,
    input  logic [3:0]        spi_io_in
);
    localparam int TX_W  = 32;
    localparam int MAX_B = (WORD_W > TX_W) ? WORD_W : TX_W;
    localparam int REM_W = $clog2(MAX_B + 1);

    seq_state_t        state;
    phase_t            phase;
    logic [REM_W-1:0]  rem;
    logic [TX_W-1:0]   txsr;
    logic [31:0]       addr_q;
    logic [CNT_W-1:0]  dly_cnt;
    logic              cs_on;
    logic              sck_rise;
    logic              sck_fall;
    logic [WORD_W-1:0] rx_word;

    // serial clock cycles spent in a phase
    function automatic logic [REM_W-1:0] phase_len(input phase_t ph);
        case (ph)
            PH_CMD:  phase_len = REM_W'(8) >> lane_log2(cfg_cmd_lanes);
            PH_ADDR: phase_len = (cfg_addr32 ? REM_W'(32) : REM_W'(24))
                                 >> lane_log2(cfg_addr_lanes);
            PH_MODE: phase_len = REM_W'(cfg_mode_clks);
            default: phase_len = REM_W'(WORD_W) >> lane_log2(cfg_data_lanes);
        endcase
    endfunction

    // phase that follows the given one
    function automatic phase_t phase_next(input phase_t ph);
        case (ph)
            PH_CMD:  phase_next = PH_ADDR;
            PH_ADDR: phase_next = (cfg_mode_clks != '0) ? PH_MODE : PH_DATA;
            default: phase_next = PH_DATA;
        endcase
    endfunction

    // left-aligned transmit value for a phase
    function automatic logic [TX_W-1:0] phase_load(input phase_t ph,
                                                   input logic [31:0] a);
        case (ph)
            PH_CMD:  phase_load = {cfg_opcode, 24'h0};
            PH_ADDR: phase_load = cfg_addr32 ? a : {a[23:0], 8'h00};
            default: phase_load = '0;
        endcase
    endfunction

    xip_sck_gen #(
        .CNT_W (CNT_W)
    ) u_sck (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state == ST_SHIFT),
        .hi_cnt (cfg_sck_hi),
        .lo_cnt (cfg_sck_lo),
        .sck    (spi_sck),
        .rise   (sck_rise),
        .fall   (sck_fall)
    );

    xip_lane_tx u_tx (
        .drive_en   (state == ST_LEAD || state == ST_SHIFT),
        .phase      (phase),
        .cmd_lanes  (cfg_cmd_lanes),
        .addr_lanes (cfg_addr_lanes),
        .tx_top     (txsr[TX_W-1 -: 4]),
        .mode_val   (cfg_mode_val),
        .io_out     (spi_io_out),
        .io_oe      (spi_io_oe)
    );

    xip_lane_rx #(
        .WORD_W (WORD_W)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (sck_rise && phase == PH_DATA),
        .lanes    (cfg_data_lanes),
        .io_in    (spi_io_in),
        .word     (rx_word)
    );

    // handshake and chip-select level
    always_comb begin
        req_ready = (state == ST_IDLE);
        spi_cs    = cfg_cs_active_high ? cs_on : ~cs_on;
    end

    // frame sequencing: accept, setup delay, phases, release delay
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            phase       <= PH_CMD;
            rem         <= '0;
            txsr        <= '0;
            addr_q      <= '0;
            dly_cnt     <= '0;
            cs_on       <= 1'b0;
            rdata       <= '0;
            rdata_valid <= 1'b0;
        end else begin
            rdata_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q  <= req_addr;
                        phase   <= cfg_skip_cmd ? PH_ADDR : PH_CMD;
                        rem     <= phase_len(cfg_skip_cmd ? PH_ADDR : PH_CMD);
                        txsr    <= phase_load(cfg_skip_cmd ? PH_ADDR : PH_CMD,
                                              req_addr);
                        cs_on   <= 1'b1;
                        dly_cnt <= '0;
                        state   <= ST_LEAD;
                    end
                end
                ST_LEAD: begin
                    if (dly_cnt == cfg_cs_lead) begin
                        state <= ST_SHIFT;
                    end else begin
                        dly_cnt <= dly_cnt + CNT_W'(1);
                    end
                end
                ST_SHIFT: begin
                    if (sck_rise) begin
                        rem <= rem - REM_W'(1);
                    end
                    if (sck_fall) begin
                        if (rem == '0) begin
                            if (phase == PH_DATA) begin
                                rdata       <= rx_word;
                                rdata_valid <= 1'b1;
                                cs_on       <= 1'b0;
                                dly_cnt     <= '0;
                                state       <= ST_TRAIL;
                            end else begin
                                phase <= phase_next(phase);
                                rem   <= phase_len(phase_next(phase));
                                txsr  <= phase_load(phase_next(phase), addr_q);
                            end
                        end else begin
                            txsr <= txsr << lane_bits((phase == PH_CMD) ?
                                                      cfg_cmd_lanes :
                                                      cfg_addr_lanes);
                        end
                    end
                end
                default: begin
                    if (dly_cnt == cfg_cs_trail) begin
                        state <= ST_IDLE;
                    end else begin
                        dly_cnt <= dly_cnt + CNT_W'(1);
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/xip_fetch_seq_chk.sv
// Cycle-level rules of the fetch sequencer, observed at its ports.
// Attached to every instance of the top module by the bind below.
module xip_fetch_seq_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cfg_sck_hi,
    input logic             cfg_cs_active_high,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rdata_valid,
    input logic             spi_sck,
    input logic             spi_cs,
    input logic [3:0]       spi_io_oe
);
    logic [CNT_W:0] hi_run;
    logic [CNT_W:0] hi_exp;

    // length of the current high pulse of the serial clock
    always_ff @(posedge clk) begin
        if (!rst_n || !spi_sck) hi_run <= '0;
        else                    hi_run <= hi_run + (CNT_W+1)'(1);
    end

    // programmed high width with zero acting as one
    always_comb hi_exp = (cfg_sck_hi == '0) ? (CNT_W+1)'(1) : {1'b0, cfg_sck_hi};

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |=> !rdata_valid); // R2
    AST_VALID_CS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |-> (spi_cs != cfg_cs_active_high)); // R2
    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R1
    AST_SCK_REST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs != cfg_cs_active_high) |-> !spi_sck); // R7
    AST_SCK_HIGH_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_sck) |-> (hi_run == hi_exp)); // R7
    AST_OE_LANE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_io_oe == 4'h0 || spi_io_oe == 4'h1 ||
         spi_io_oe == 4'h3 || spi_io_oe == 4'hF)); // R3
    AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (spi_io_oe == 4'h0)); // R10

endmodule

bind xip_fetch_seq xip_fetch_seq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk                (clk),
    .rst_n              (rst_n),
    .cfg_sck_hi         (cfg_sck_hi),
    .cfg_cs_active_high (cfg_cs_active_high),
    .req_valid          (req_valid),
    .req_ready          (req_ready),
    .rdata_valid        (rdata_valid),
    .spi_sck            (spi_sck),
    .spi_cs             (spi_cs),
    .spi_io_oe          (spi_io_oe)
);

// File: tb/sim_xip_fetch_seq.sv
`timescale 1ns/1ps
// Scoreboard bench: the request task queues the expected word, a flash
// model answers on the serial pins, and the monitor compares each frame.
module sim_xip_fetch_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_opcode = 8'h03;
    logic [1:0]  cfg_cmd_lanes = 2'd0;
    logic [1:0]  cfg_addr_lanes = 2'd0;
    logic [1:0]  cfg_data_lanes = 2'd0;
    logic        cfg_addr32 = 1'b0;
    logic        cfg_skip_cmd = 1'b0;
    logic [3:0]  cfg_mode_clks = 4'd0;
    logic [3:0]  cfg_mode_val = 4'h0;
    logic [3:0]  cfg_sck_hi = 4'd1;
    logic [3:0]  cfg_sck_lo = 4'd1;
    logic        cfg_cs_high = 1'b0;
    logic [3:0]  cfg_cs_lead = 4'd0;
    logic [3:0]  cfg_cs_trail = 4'd0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ready;
    logic [31:0] rdata;
    logic        rdata_valid;
    logic        spi_sck;
    logic        spi_cs;
    logic [3:0]  spi_io_out;
    logic [3:0]  spi_io_oe;
    logic [3:0]  spi_io_in = 4'h0;

    always #2 clk = ~clk;

    xip_fetch_seq u0 (
        .clk (clk), .rst_n (rst_n),
        .cfg_opcode (cfg_opcode), .cfg_cmd_lanes (cfg_cmd_lanes),
        .cfg_addr_lanes (cfg_addr_lanes), .cfg_data_lanes (cfg_data_lanes),
        .cfg_addr32 (cfg_addr32), .cfg_skip_cmd (cfg_skip_cmd),
        .cfg_mode_clks (cfg_mode_clks), .cfg_mode_val (cfg_mode_val),
        .cfg_sck_hi (cfg_sck_hi), .cfg_sck_lo (cfg_sck_lo),
        .cfg_cs_active_high (cfg_cs_high), .cfg_cs_lead (cfg_cs_lead),
        .cfg_cs_trail (cfg_cs_trail),
        .req_valid (req_valid), .req_addr (req_addr), .req_ready (req_ready),
        .rdata (rdata), .rdata_valid (rdata_valid),
        .spi_sck (spi_sck), .spi_cs (spi_cs),
        .spi_io_out (spi_io_out), .spi_io_oe (spi_io_oe), .spi_io_in (spi_io_in)
    );

    typedef struct {
        logic [31:0] word;
        logic [31:0] addr;
        bit          chk_gap;
    } exp_t;
    exp_t expq[$];

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int lw(input logic [1:0] c);
        return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
    endfunction
    function automatic int eff(input logic [3:0] v);
        return (v == 4'd0) ? 1 : int'(v);
    endfunction
    function automatic logic [31:0] word_of(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5A5A1234;
    endfunction
    function automatic logic [3:0] oe_mask(input int l);
        return (l == 1) ? 4'h1 : (l == 2) ? 4'h3 : 4'hF;
    endfunction
    function automatic logic [3:0] pick(input logic [3:0] v, input int l);
        return (l == 1) ? {3'b0, v[0]} : (l == 2) ? {2'b0, v[1:0]} : v;
    endfunction

    // flash model and monitor state
    bit          was_act = 0;
    bit          prev_sck = 0;
    int          rises = 0;
    int          lead_cnt = 0;
    int          lead_meas = 0;
    int          lowrun = 0;
    int          hirun = 0;
    int          gap_cnt = 0;
    int          gap_meas = 0;
    logic [31:0] cap_op = '0;
    logic [31:0] cap_addr = '0;
    bit          width_err = 0;
    bit          mode_err = 0;
    bit          oe_err = 0;
    bit          ready_err = 0;

    // monitor first, then flash model, all away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            int nc, na, nm, nd, pre;
            bit act, rise, fall;
            nc  = cfg_skip_cmd ? 0 : 8 / lw(cfg_cmd_lanes);
            na  = (cfg_addr32 ? 32 : 24) / lw(cfg_addr_lanes);
            nm  = int'(cfg_mode_clks);
            nd  = 32 / lw(cfg_data_lanes);
            pre = nc + na + nm;
            if (rdata_valid) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R2 unexpected word", rdata, 32'h0);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    chk(rdata == e.word, "R2 fetched word", rdata, e.word);
                    chk(rises == pre + nd, "R3/R4 clock count", 32'(rises),
                        32'(pre + nd));
                    if (!cfg_skip_cmd)
                        chk(cap_op == {24'h0, cfg_opcode}, "R3 opcode", cap_op,
                            {24'h0, cfg_opcode});
                    chk(cap_addr == e.addr, "R5 address", cap_addr, e.addr);
                    chk(!mode_err, "R6 mode value", 32'(mode_err), 32'h0);
                    chk(!oe_err, "R10 output enables", 32'(oe_err), 32'h0);
                    chk(!width_err, "R7 sck widths", 32'(width_err), 32'h0);
                    chk(!ready_err, "R1 ready in frame", 32'(ready_err), 32'h0);
                    chk(lead_meas == int'(cfg_cs_lead) + 1 + eff(cfg_sck_lo),
                        "R9 lead", 32'(lead_meas),
                        32'(int'(cfg_cs_lead) + 1 + eff(cfg_sck_lo)));
                    if (e.chk_gap)
                        chk(gap_meas == int'(cfg_cs_trail) + 2, "R9 trail gap",
                            32'(gap_meas), 32'(int'(cfg_cs_trail) + 2));
                end
            end
            act = (spi_cs === cfg_cs_high);
            if (!act) begin
                if (was_act) gap_cnt = 0;
                gap_cnt++;
                rises = 0; lead_cnt = 0; lowrun = 0; hirun = 0;
                cap_op = '0; cap_addr = '0;
                width_err = 0; mode_err = 0; oe_err = 0; ready_err = 0;
                spi_io_in = 4'h0;
            end else begin
                if (!was_act) gap_meas = gap_cnt;
                if (req_ready) ready_err = 1;
                rise = spi_sck && !prev_sck;
                fall = !spi_sck && prev_sck;
                if (rise) begin
                    if (rises == 0) lead_meas = lead_cnt;
                    else if (lowrun != eff(cfg_sck_lo)) width_err = 1;
                    lowrun = 0;
                    if (rises < nc) begin
                        cap_op = (cap_op << lw(cfg_cmd_lanes)) |
                                 32'(pick(spi_io_out, lw(cfg_cmd_lanes)));
                        if (spi_io_oe != oe_mask(lw(cfg_cmd_lanes))) oe_err = 1;
                    end else if (rises < nc + na) begin
                        cap_addr = (cap_addr << lw(cfg_addr_lanes)) |
                                   32'(pick(spi_io_out, lw(cfg_addr_lanes)));
                        if (spi_io_oe != oe_mask(lw(cfg_addr_lanes))) oe_err = 1;
                    end else if (rises < pre) begin
                        if (spi_io_out != cfg_mode_val || spi_io_oe != 4'hF)
                            mode_err = 1;
                    end else if (spi_io_oe != 4'h0) begin
                        oe_err = 1;
                    end
                    rises++;
                end
                if (fall) begin
                    if (hirun != eff(cfg_sck_hi)) width_err = 1;
                    hirun = 0;
                    if (rises >= pre && rises - pre < nd) begin
                        int b, j;
                        logic [31:0] w, g;
                        b = lw(cfg_data_lanes);
                        j = rises - pre;
                        w = word_of(cap_addr);
                        g = (w >> (32 - b * (j + 1))) & ((32'h1 << b) - 1);
                        spi_io_in = (b == 1) ? {2'b00, g[0], 1'b0} : g[3:0];
                    end
                end
                if (spi_sck) hirun++;
                else begin
                    lowrun++;
                    if (rises == 0) lead_cnt++;
                end
            end
            was_act  = act;
            prev_sck = spi_sck;
        end
    end

    // driver: queue the expected item, hold the request until accepted
    task automatic fetch(input logic [31:0] a);
        exp_t e;
        e.addr    = cfg_addr32 ? a : {8'h00, a[23:0]};
        e.word    = word_of(e.addr);
        e.chk_gap = !req_ready;
        expq.push_back(e);
        req_valid = 1'b1;
        req_addr  = a;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (expq.size() != 0 || !req_ready) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R1 watchdog expired");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'h1);
        chk(rdata_valid == 1'b0, "R1 valid after reset", 32'(rdata_valid), 32'h0);
        chk(spi_sck == 1'b0, "R7 sck after reset", 32'(spi_sck), 32'h0);
        chk(spi_io_oe == 4'h0, "R10 oe after reset", 32'(spi_io_oe), 32'h0);
        chk(spi_cs == 1'b1, "R8 active-low idle level", 32'(spi_cs), 32'h1);

        // all single line, 24-bit address, back to back
        fetch(32'hA5123456);
        fetch(32'h00FFFFFC);
        wait_idle();

        // R6 mode clocks with quad address/data, 32-bit address, slow clock
        cfg_opcode = 8'hEC; cfg_addr_lanes = 2'd2; cfg_data_lanes = 2'd2;
        cfg_addr32 = 1'b1; cfg_mode_clks = 4'd2; cfg_mode_val = 4'hA;
        cfg_sck_hi = 4'd2; cfg_sck_lo = 4'd3; cfg_cs_lead = 4'd3;
        cfg_cs_trail = 4'd4;
        fetch(32'h80001000);
        fetch(32'h12345678);
        wait_idle();

        // R4 no opcode, R8 active-high select, R7 zero widths act as one
        cfg_skip_cmd = 1'b1; cfg_cs_high = 1'b1; cfg_sck_hi = 4'd0;
        cfg_sck_lo = 4'd0; cfg_mode_clks = 4'd0; cfg_cs_lead = 4'd0;
        cfg_cs_trail = 4'd1;
        @(negedge clk);
        chk(spi_cs == 1'b0, "R8 active-high idle level", 32'(spi_cs), 32'h0);
        fetch(32'hDEADBEEF);
        fetch(32'h0000000F);
        wait_idle();

        // R3 all dual lines, 24-bit address, long mode stretch, widest clock
        cfg_skip_cmd = 1'b0; cfg_opcode = 8'hBB; cfg_cmd_lanes = 2'd1;
        cfg_addr_lanes = 2'd1; cfg_data_lanes = 2'd1; cfg_addr32 = 1'b0;
        cfg_mode_clks = 4'd4; cfg_mode_val = 4'h5; cfg_sck_hi = 4'd15;
        cfg_sck_lo = 4'd15; cfg_cs_lead = 4'd15; cfg_cs_trail = 4'd15;
        fetch(32'h7F3C2A19);
        fetch(32'h55AA55AA);
        wait_idle();

        // R3 four-line opcode, lane code 3 as four lines, single-line data
        cfg_cmd_lanes = 2'd2; cfg_addr_lanes = 2'd3; cfg_data_lanes = 2'd0;
        cfg_addr32 = 1'b1; cfg_mode_clks = 4'd1; cfg_mode_val = 4'h3;
        cfg_sck_hi = 4'd1; cfg_sck_lo = 4'd2; cfg_cs_lead = 4'd2;
        cfg_cs_trail = 4'd0; cfg_cs_high = 1'b0;
        fetch(32'hFFFFFFFF);
        fetch(32'h00000000);
        fetch(32'hC0FFEE00);
        wait_idle();
        chk(req_ready == 1'b1, "R1 ready when idle", 32'(req_ready), 32'h1);
        finish_run();
    end

endmodule